// File: doc/BRIEF.md
# Pausable Sequential Integer Divider

This block divides a dividend by a 16-bit divisor one quotient bit at a time. The dividend is either 16 or 32 bits wide, and the operands are either unsigned or two's-complement. The block returns a 16-bit quotient and a 16-bit remainder. An operation always uses nineteen advancing steps: one setup step, sixteen quotient-bit steps and two fix-up steps. A step happens only on a clock edge where the step-enable input is high. While step-enable is low, every internal register holds its value, so a surrounding sequencer can suspend the operation for any number of cycles and then continue it with no loss of data.

The controller is a five-state machine. `ST_IDLE` moves to `ST_SETUP` when start is accepted. `ST_SETUP` takes the magnitudes and signs of the operands and moves to `ST_ITER` on a step. `ST_ITER` stays in place for sixteen steps and then moves to `ST_FIX_Q`. `ST_FIX_Q` applies the quotient sign and checks the signed range, then moves to `ST_FIX_R` on a step. `ST_FIX_R` applies the remainder sign and returns to `ST_IDLE` on a step, which raises done. In every state except `ST_IDLE`, a cycle with step-enable low keeps the same state.

Top module: `iter_divider`

## Requirements
- R1: A start pulse sampled while busy is low latches the dividend, the divisor, wide_mode and signed_mode. Busy is high from the next cycle onward.
- R2: Busy falls and done rises in the cycle that follows exactly 19 clock edges at which busy and step_en were both high.
- R3: While busy is high and step_en is low, busy stays high and quotient and remainder keep their values in the next cycle.
- R4: With wide_mode=0 and signed_mode=0, the dividend is dividend[15:0] with zero extension, and the results are the unsigned quotient and remainder.
- R5: With wide_mode=1 and signed_mode=0, the full 32-bit dividend is divided unsigned.
- R6: With signed_mode=1, the operands are two's-complement, and with wide_mode=0 dividend[15:0] is sign-extended. The quotient truncates toward zero, and the remainder takes the sign of the dividend or is zero.
- R7: A zero divisor still takes 19 steps, sets div_zero and clears overflow. Quotient and remainder are then undefined.
- R8: overflow is set when the true quotient does not fit in 16 bits: above 65535 when unsigned, or outside -32768..32767 when signed. This applies in both modes. Quotient and remainder are then undefined.
- R9: A start pulse while busy is high has no effect on the running operation or its results.
- R10: done is high for exactly one cycle per operation.
- R11: Inserting stall cycles before any steps leaves the results and flags identical to an unstalled run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| step_en | input | 1 | Advance one step on this edge; low holds all state |
| wide_mode | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| signed_mode | input | 1 | 1: two's-complement operands |
| dividend | input | 32 | Dividend; only [15:0] used when wide_mode=0 |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Quotient, valid when done |
| remainder | output | 16 | Remainder, valid when done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the final step |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient out of 16-bit range |

## Verification
The properties assume that rst_n is held low before the first edge that matters. They also assume that start and step_en are clean, single-bit levels that change only between clock edges. Outside of those, step_en may follow any pattern. The stimulus drives every input on the falling edge and samples on the next falling edge. It mixes free-running steps, periodic stalls and a stray start inside an operation. This exercises the hold and step-count properties without needing any particular step_en pattern from the environment.

// File: rtl/divider_pkg.sv
package divider_pkg;
    localparam int QBITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ITER,
        ST_FIX_Q,
        ST_FIX_R
    } div_state_t;
endpackage

// File: rtl/divider_ctrl.sv
module divider_ctrl
    import divider_pkg::*;
#(
    parameter int W = QBITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step_en,
    output logic busy,
    output logic done,
    output logic load,
    output logic do_setup,
    output logic do_iter,
    output logic do_fix_q,
    output logic do_fix_r
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    div_state_t state, state_nx;
    logic [CNT_W-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (do_setup)
                bit_cnt <= '0;
            else if (do_iter)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_SETUP;
            ST_SETUP: if (step_en) state_nx = ST_ITER;
            ST_ITER:  if (step_en && bit_cnt == LAST) state_nx = ST_FIX_Q;
            ST_FIX_Q: if (step_en) state_nx = ST_FIX_R;
            ST_FIX_R: if (step_en) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        load     = (state == ST_IDLE) && start;
        do_setup = (state == ST_SETUP) && step_en;
        do_iter  = (state == ST_ITER) && step_en;
        do_fix_q = (state == ST_FIX_Q) && step_en;
        do_fix_r = (state == ST_FIX_R) && step_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= do_fix_r;
    end
endmodule

// File: rtl/divider_core.sv
module divider_core #(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            do_setup,
    input  logic            do_iter,
    input  logic            do_fix_q,
    input  logic            do_fix_r,
    input  logic            wide_in,
    input  logic            sgn_in,
    input  logic [2*W-1:0]  dvd_in,
    input  logic [W-1:0]    dvs_in,
    output logic [W-1:0]    q_out,
    output logic [W-1:0]    r_out,
    output logic            zero_flag,
    output logic            ovf_flag
);
    localparam int DW = 2 * W;
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    logic [DW-1:0] dvd_l;
    logic [W-1:0]  dvs_l;
    logic          wide_l, sgn_l;
    logic [DW-1:0] acc;
    logic [W-1:0]  dmag;
    logic          neg_q, neg_r;

    // setup-step operand conditioning
    logic [DW-1:0] dvd_ext;
    logic          dvd_neg, dvs_neg;
    always_comb begin
        if (wide_l)
            dvd_ext = dvd_l;
        else if (sgn_l)
            dvd_ext = {{W{dvd_l[W-1]}}, dvd_l[W-1:0]};
        else
            dvd_ext = {{W{1'b0}}, dvd_l[W-1:0]};
        dvd_neg = sgn_l & dvd_ext[DW-1];
        dvs_neg = sgn_l & dvs_l[W-1];
    end

    // one restoring trial-subtract step
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic         fits;
    logic [W-1:0] part_nx;
    always_comb begin
        trial   = {acc[DW-1:W], acc[W-1]};
        diff    = trial - {1'b0, dmag};
        fits    = (trial >= {1'b0, dmag});
        part_nx = fits ? diff[W-1:0] : trial[W-1:0];
    end

    logic [W-1:0] qmag;
    logic         sgn_range_bad;
    always_comb begin
        qmag          = acc[W-1:0];
        sgn_range_bad = neg_q ? (qmag > NEG_LIMIT) : qmag[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_l     <= '0;
            dvs_l     <= '0;
            wide_l    <= 1'b0;
            sgn_l     <= 1'b0;
            acc       <= '0;
            dmag      <= '0;
            neg_q     <= 1'b0;
            neg_r     <= 1'b0;
            q_out     <= '0;
            r_out     <= '0;
            zero_flag <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            if (load) begin
                dvd_l  <= dvd_in;
                dvs_l  <= dvs_in;
                wide_l <= wide_in;
                sgn_l  <= sgn_in;
            end
            if (do_setup) begin
                acc       <= dvd_neg ? -dvd_ext : dvd_ext;
                dmag      <= dvs_neg ? -dvs_l : dvs_l;
                neg_q     <= dvd_neg ^ dvs_neg;
                neg_r     <= dvd_neg;
                zero_flag <= (dvs_l == '0);
                ovf_flag  <= (dvs_l != '0) &&
                             ((dvd_neg ? -dvd_ext : dvd_ext) >> W) >=
                             DW'(dvs_neg ? -dvs_l : dvs_l);
            end
            if (do_iter)
                acc <= {part_nx, acc[W-2:0], fits};
            if (do_fix_q) begin
                q_out <= neg_q ? -qmag : qmag;
                if (sgn_l && !zero_flag && sgn_range_bad)
                    ovf_flag <= 1'b1;
            end
            if (do_fix_r)
                r_out <= neg_r ? -acc[DW-1:W] : acc[DW-1:W];
        end
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import divider_pkg::*;
#(
    parameter int W = QBITS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           step_en,
    input  logic           wide_mode,
    input  logic           signed_mode,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder,
    output logic           busy,
    output logic           done,
    output logic           div_zero,
    output logic           overflow
);
    logic load, do_setup, do_iter, do_fix_q, do_fix_r;

    divider_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .step_en  (step_en),
        .busy     (busy),
        .done     (done),
        .load     (load),
        .do_setup (do_setup),
        .do_iter  (do_iter),
        .do_fix_q (do_fix_q),
        .do_fix_r (do_fix_r)
    );

    divider_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .do_setup  (do_setup),
        .do_iter   (do_iter),
        .do_fix_q  (do_fix_q),
        .do_fix_r  (do_fix_r),
        .wide_in   (wide_mode),
        .sgn_in    (signed_mode),
        .dvd_in    (dividend),
        .dvs_in    (divisor),
        .q_out     (quotient),
        .r_out     (remainder),
        .zero_flag (div_zero),
        .ovf_flag  (overflow)
    );
endmodule

// File: rtl/div_checker.sv
module div_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         step_en,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic         overflow,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    localparam int TOTAL = W + 3;
    localparam int CW    = $clog2(TOTAL + 1) + 1;

    logic [CW-1:0] steps_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            steps_seen <= '0;
        else if (start && !busy)
            steps_seen <= '0;
        else if (busy && step_en)
            steps_seen <= steps_seen + 1'b1;
    end

    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    // R2
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> steps_seen == CW'(TOTAL));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !step_en |=> busy && $stable(quotient) && $stable(remainder));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(div_zero && overflow));
endmodule

bind iter_divider div_checker #(.W(W)) u_div_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_en   (step_en),
    .busy      (busy),
    .done      (done),
    .div_zero  (div_zero),
    .overflow  (overflow),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/test_iter_divider.sv
`timescale 1ns/1ps
module test_iter_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        step_en = 1'b0;
    logic        wide_mode = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [15:0] quotient, remainder;
    logic        busy, done, div_zero, overflow;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    iter_divider i_iter_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en),
        .wide_mode(wide_mode), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .remainder(remainder),
        .busy(busy), .done(done), .div_zero(div_zero), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // stall_n > 0: a stall cycle precedes every step whose index is a multiple of stall_n
    // poke: a stray start with other operands during step 5
    task automatic run_op(input bit wide, input bit sgn, input logic [31:0] a,
                          input logic [15:0] b, input int stall_n, input bit poke,
                          input string req);
        longint na, nb, q, r;
        bit     zero, ovf;
        int     steps = 0;
        int     guard = 0;
        logic [15:0] q_before;
        na = wide ? (sgn ? longint'($signed(a)) : longint'(a))
                  : (sgn ? longint'($signed(a[15:0])) : longint'(a[15:0]));
        nb = sgn ? longint'($signed(b)) : longint'(b);
        zero = (nb == 0);
        q = zero ? 0 : na / nb;
        r = zero ? 0 : na % nb;
        ovf = !zero && (sgn ? (q > 32767 || q < -32768) : (q > 65535));

        @(negedge clk);
        start = 1'b1; wide_mode = wide; signed_mode = sgn;
        dividend = a; divisor = b; step_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        while (!done && guard < 200) begin
            guard++;
            if (stall_n > 0 && (steps % stall_n) == 0 && steps != 0 && step_en == 1'b1) begin
                step_en = 1'b0;
                q_before = quotient;
                @(negedge clk);
                chk(busy == 1'b1 && quotient == q_before, "R3", "hold during stall",
                    busy, 1);
            end else begin
                step_en = 1'b1;
                start = (poke && steps == 5);
                if (poke && steps == 5) begin
                    dividend = 32'h0000_0003; divisor = 16'h0001;
                    wide_mode = ~wide; signed_mode = ~sgn;
                end
                steps++;
                @(negedge clk);
                start = 1'b0;
            end
        end
        step_en = 1'b0;
        chk(steps == 19, "R2", "step count to done", steps, 19);
        chk(busy == 1'b0, "R2", "busy low at done", busy, 0);
        chk(div_zero == zero, req, "div_zero flag", div_zero, zero);
        chk(overflow == ovf, req, "overflow flag", overflow, ovf);
        if (!zero && !ovf) begin
            chk(quotient == q[15:0], req, "quotient", quotient, q[15:0]);
            chk(remainder == r[15:0], req, "remainder", remainder, r[15:0]);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done one cycle", done, 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", busy, 0);
        chk(quotient == 16'd0 && remainder == 16'd0, "R1", "results after reset",
            quotient, 0);
    endtask

    task automatic t_unsigned_narrow();
        run_op(1'b0, 1'b0, 32'hABCD_03E8, 16'd7, 0, 1'b0, "R4");
        run_op(1'b0, 1'b0, 32'h0000_FFFF, 16'd1, 0, 1'b0, "R4");
        run_op(1'b0, 1'b0, 32'h0000_0005, 16'd9, 0, 1'b0, "R4");
    endtask

    task automatic t_unsigned_wide();
        run_op(1'b1, 1'b0, 32'h1234_5678, 16'h9ABC, 0, 1'b0, "R5");
        run_op(1'b1, 1'b0, 32'hFFFE_0001, 16'hFFFF, 0, 1'b0, "R5");
    endtask

    task automatic t_signed();
        run_op(1'b0, 1'b1, 32'h0000_FFF9, 16'd2, 0, 1'b0, "R6");
        run_op(1'b0, 1'b1, 32'h0000_0007, 16'hFFFE, 0, 1'b0, "R6");
        run_op(1'b1, 1'b1, 32'hFFFE_7960, 16'd7, 0, 1'b0, "R6");
        run_op(1'b1, 1'b1, 32'hFFFF_0000, 16'd2, 0, 1'b0, "R6");
    endtask

    task automatic t_overflow();
        run_op(1'b1, 1'b0, 32'h0001_0000, 16'd1, 0, 1'b0, "R8");
        run_op(1'b0, 1'b1, 32'h0000_8000, 16'hFFFF, 0, 1'b0, "R8");
        run_op(1'b1, 1'b1, 32'h8000_0000, 16'd3, 0, 1'b0, "R8");
        run_op(1'b1, 1'b1, 32'h0000_8000, 16'd1, 0, 1'b0, "R8");
    endtask

    task automatic t_div_zero();
        run_op(1'b0, 1'b0, 32'h0000_1234, 16'd0, 0, 1'b0, "R7");
        run_op(1'b1, 1'b1, 32'h8765_4321, 16'd0, 0, 1'b0, "R7");
    endtask

    task automatic t_stall();
        run_op(1'b1, 1'b0, 32'h1234_5678, 16'h9ABC, 2, 1'b0, "R11");
        run_op(1'b1, 1'b1, 32'hFFFE_7960, 16'd7, 3, 1'b0, "R11");
    endtask

    task automatic t_ignore_start();
        run_op(1'b1, 1'b0, 32'h0FED_CBA9, 16'h4321, 0, 1'b1, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned_narrow();
        t_unsigned_wide();
        t_signed();
        t_overflow();
        t_div_zero();
        t_stall();
        t_ignore_start();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule